// File: doc/BRIEF.md
# Task Priority Interrupt Gate

This block holds a small programmable priority threshold and uses it to filter external interrupt requests before they reach a processor core. Software loads the threshold through a 64-bit write port and can read the full register back at any time. Only the four low bits carry the threshold. Every other bit must be written as zero, and a write that breaks this rule is refused.

Each interrupt request arrives as a valid strobe with an 8-bit vector. The upper nibble of the vector is the request's priority class. The gate decides in the same cycle whether the request passes or is masked. A request passes only when its class is strictly higher than the stored threshold. A passed vector is handed on through a registered output stage one cycle later, so a threshold of 0 opens the gate to every real class and a threshold of 15 shuts it completely.

Top module: `prio_irq_gate`

## Requirements
- R1: `rd_data` always shows the threshold in bits 3:0, and bits 63:4 always read as zero.
- R2: A write whose bits 63:4 are all zero loads bits 3:0 into the threshold, and the new value is visible on `rd_data` from the cycle after the write.
- R3: A write with any of bits 63:4 set leaves the threshold unchanged and raises `wr_err` for exactly the one cycle following the write.
- R4: After synchronous reset the threshold is 0, `wr_err` is low, `out_valid` is low and `out_vector` is zero.
- R5: The class of a request is `req_vector[7:4]`. `req_accept` is high in the same cycle exactly when `req_valid` is high and the class is strictly greater than the threshold.
- R6: A valid request whose class is less than or equal to the threshold raises `req_masked` and not `req_accept`, and neither output is high without `req_valid`.
- R7: With a threshold of 0, every request of class 1 to 15 is accepted, and a class-0 vector is never accepted at any threshold.
- R8: With a threshold of 15, every request is masked.
- R9: One cycle after an accepted request, `out_valid` is high and `out_vector` carries that vector. After any other cycle, `out_valid` is low and `out_vector` is zero.
- R10: A write changes the decision only for requests from the next cycle onward. A request in the same cycle as the write is judged against the old threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Threshold register write strobe |
| wr_data | input | 64 | Write data; bits 3:0 are the threshold, bits 63:4 must be zero |
| rd_data | output | 64 | Read-back of the threshold register, zero-extended |
| wr_err | output | 1 | One-cycle pulse after a refused write |
| req_valid | input | 1 | Interrupt request strobe |
| req_vector | input | 8 | Request vector; bits 7:4 give the priority class |
| req_accept | output | 1 | Same-cycle pass decision |
| req_masked | output | 1 | Same-cycle mask decision |
| out_valid | output | 1 | Registered flag for a passed request |
| out_vector | output | 8 | Registered vector of the passed request |

## Verification
The assertions assume that the write data and the request vector are fully known whenever their strobes are high, and that reset is held for at least one clock edge before any check applies. The stimulus drives every input only after the falling edge, so all inputs settle well before the rising edge. It holds the strobes low in the cycles where no operation is meant. The stimulus also keeps the write and request strobes at defined levels from time zero, so no decision is ever made on unknown data.

// File: rtl/prio_gate_pkg.sv
package prio_gate_pkg;

  // Classification of a write attempt on the threshold port
  typedef enum logic [1:0] {
    WR_IDLE = 2'd0,
    WR_OK   = 2'd1,
    WR_BAD  = 2'd2
  } wr_kind_e;

  // Class of a request: the top PW bits of a VW-bit vector
  function automatic logic [3:0] class_of(input logic [7:0] vec);
    return vec[7:4];
  endfunction

endpackage

// File: rtl/prio_reg.sv
module prio_reg
  import prio_gate_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int PRIO_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [PRIO_W-1:0] prio,
  output logic              wr_err
);
  localparam int RSV_W = DATA_W - PRIO_W;

  wr_kind_e             kind;
  logic     [RSV_W-1:0] rsv_bits;

  assign rsv_bits = wr_data[DATA_W-1:PRIO_W];

  always_comb begin
    if (!wr_en)
      kind = WR_IDLE;
    else if (|rsv_bits)
      kind = WR_BAD;
    else
      kind = WR_OK;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prio   <= '0;
      wr_err <= 1'b0;
    end else begin
      wr_err <= (kind == WR_BAD);
      if (kind == WR_OK)
        prio <= wr_data[PRIO_W-1:0];
    end
  end
endmodule

// File: rtl/prio_compare.sv
module prio_compare #(
  parameter int PRIO_W = 4,
  parameter int VEC_W  = 8
) (
  input  logic              req_valid,
  input  logic [VEC_W-1:0]  req_vector,
  input  logic [PRIO_W-1:0] prio,
  output logic              req_accept,
  output logic              req_masked
);
  localparam int CLS_LSB = VEC_W - PRIO_W;

  logic [PRIO_W-1:0] req_class;
  logic              above;

  assign req_class = req_vector[VEC_W-1:CLS_LSB];
  assign above     = (req_class > prio);

  always_comb begin
    req_accept = req_valid && above;
    req_masked = req_valid && !above;
  end
endmodule

// File: rtl/vec_out_stage.sv
module vec_out_stage #(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             accept,
  input  logic [VEC_W-1:0] vector,
  output logic             out_valid,
  output logic [VEC_W-1:0] out_vector
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_vector <= '0;
    end else begin
      out_valid  <= accept;
      out_vector <= accept ? vector : '0;
    end
  end
endmodule

// File: rtl/prio_irq_gate.sv
module prio_irq_gate #(
  parameter int DATA_W = 64,
  parameter int PRIO_W = 4,
  parameter int VEC_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              wr_err,
  input  logic              req_valid,
  input  logic [VEC_W-1:0]  req_vector,
  output logic              req_accept,
  output logic              req_masked,
  output logic              out_valid,
  output logic [VEC_W-1:0]  out_vector
);
  localparam int RSV_W = DATA_W - PRIO_W;

  logic [PRIO_W-1:0] prio;

  prio_reg #(.DATA_W(DATA_W), .PRIO_W(PRIO_W)) u_reg (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .wr_data(wr_data),
    .prio   (prio),
    .wr_err (wr_err)
  );

  prio_compare #(.PRIO_W(PRIO_W), .VEC_W(VEC_W)) u_cmp (
    .req_valid (req_valid),
    .req_vector(req_vector),
    .prio      (prio),
    .req_accept(req_accept),
    .req_masked(req_masked)
  );

  vec_out_stage #(.VEC_W(VEC_W)) u_out (
    .clk       (clk),
    .rst       (rst),
    .accept    (req_accept),
    .vector    (req_vector),
    .out_valid (out_valid),
    .out_vector(out_vector)
  );

  assign rd_data = {{RSV_W{1'b0}}, prio};
endmodule

// File: rtl/prio_irq_gate_chk.sv
module prio_irq_gate_chk #(
  parameter int DATA_W = 64,
  parameter int PRIO_W = 4,
  parameter int VEC_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] rd_data,
  input logic              wr_err,
  input logic              req_valid,
  input logic [VEC_W-1:0]  req_vector,
  input logic              req_accept,
  input logic              req_masked,
  input logic              out_valid,
  input logic [VEC_W-1:0]  out_vector
);
  localparam int CLS_LSB = VEC_W - PRIO_W;
  localparam logic [PRIO_W-1:0] PRIO_MAX = '1;

  assert_rsv_zero_R1: assert property (@(posedge clk) disable iff (rst)
    rd_data[DATA_W-1:PRIO_W] == '0);

  assert_good_write_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_data[DATA_W-1:PRIO_W] == '0) |=> (rd_data == $past(wr_data) && !wr_err));

  assert_bad_write_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_data[DATA_W-1:PRIO_W] != '0) |=> (wr_err && $stable(rd_data)));

  assert_err_cause_R3: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> !wr_err);

  assert_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
    !(req_accept && req_masked) && ((req_accept || req_masked) == req_valid));

  assert_open_gate_R7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && rd_data[PRIO_W-1:0] == '0 && req_vector[VEC_W-1:CLS_LSB] != '0) |-> req_accept);

  assert_class0_R7: assert property (@(posedge clk) disable iff (rst)
    (req_vector[VEC_W-1:CLS_LSB] == '0) |-> !req_accept);

  assert_closed_gate_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_data[PRIO_W-1:0] == PRIO_MAX) |-> !req_accept);

  assert_pass_out_R9: assert property (@(posedge clk) disable iff (rst)
    req_accept |=> (out_valid && out_vector == $past(req_vector)));

  assert_idle_out_R9: assert property (@(posedge clk) disable iff (rst)
    !req_accept |=> (!out_valid && out_vector == '0));
endmodule

bind prio_irq_gate prio_irq_gate_chk #(
  .DATA_W(DATA_W),
  .PRIO_W(PRIO_W),
  .VEC_W (VEC_W)
) u_chk (.*);

// File: tb/sim_prio_irq_gate.sv
`timescale 1ns/1ps
module sim_prio_irq_gate;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [63:0] wr_data = '0;
  logic [63:0] rd_data;
  logic        wr_err;
  logic        req_valid = 1'b0;
  logic [7:0]  req_vector = '0;
  logic        req_accept;
  logic        req_masked;
  logic        out_valid;
  logic [7:0]  out_vector;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  prio_irq_gate u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .wr_err(wr_err), .req_valid(req_valid), .req_vector(req_vector),
    .req_accept(req_accept), .req_masked(req_masked),
    .out_valid(out_valid), .out_vector(out_vector)
  );

  // {threshold[3:0], vector[7:0], expected accept}
  localparam int NV = 12;
  localparam logic [12:0] VECS [NV] = '{
    {4'd0,  8'h15, 1'b1}, {4'd0,  8'h05, 1'b0}, {4'd0,  8'hF0, 1'b1},
    {4'd9,  8'h9A, 1'b0}, {4'd9,  8'hA0, 1'b1}, {4'd15, 8'hFF, 1'b0},
    {4'd1,  8'h1C, 1'b0}, {4'd1,  8'h2C, 1'b1}, {4'd7,  8'h83, 1'b1},
    {4'd7,  8'h7F, 1'b0}, {4'd14, 8'hF1, 1'b1}, {4'd14, 8'hE1, 0}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_prio(input logic [63:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d; req_valid = 1'b0;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  // Issue a request at a negedge, check the same-cycle decision, then the output stage
  task automatic try_req(input string req, input logic [7:0] v, input logic exp);
    req_valid = 1'b1; req_vector = v;
    #1;
    chk({req, " accept"}, {63'd0, req_accept}, {63'd0, exp});
    chk({req, " masked"}, {63'd0, req_masked}, {63'd0, !exp});
    @(negedge clk);
    req_valid = 1'b0; req_vector = '0;
    #1;
    chk("R9 out_valid", {63'd0, out_valid}, {63'd0, exp});
    chk("R9 out_vector", {56'd0, out_vector}, {56'd0, exp ? v : 8'h00});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R4 rd_data", rd_data, 64'd0);
    chk("R4 wr_err", {63'd0, wr_err}, 64'd0);
    chk("R4 out_valid", {63'd0, out_valid}, 64'd0);
    chk("R4 out_vector", {56'd0, out_vector}, 64'd0);

    // Table walk: R5, R6, R7, R8, R9
    for (int i = 0; i < NV; i++) begin
      write_prio({60'd0, VECS[i][12:9]});
      chk("R2 readback", rd_data, {60'd0, VECS[i][12:9]});
      try_req("R5", VECS[i][8:1], VECS[i][0]);
    end

    // R7: threshold 0 passes every class but 0
    write_prio(64'd0);
    for (int c = 0; c < 16; c++) try_req("R7", {c[3:0], 4'h3}, (c != 0));

    // R8: threshold 15 blocks every class
    write_prio(64'd15);
    for (int c = 0; c < 16; c++) try_req("R8", {c[3:0], 4'hA}, 1'b0);

    // R6: no decision without a valid strobe
    @(negedge clk);
    req_vector = 8'hF0; req_valid = 1'b0;
    #1;
    chk("R6 idle accept", {63'd0, req_accept}, 64'd0);
    chk("R6 idle masked", {63'd0, req_masked}, 64'd0);

    // R3: refused writes, low reserved bit and top bit
    write_prio(64'd6);
    @(negedge clk);
    wr_en = 1'b1; wr_data = 64'h12;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
    #1;
    chk("R3 err pulse", {63'd0, wr_err}, 64'd1);
    chk("R3 value kept", rd_data, 64'd6);
    @(negedge clk);
    #1;
    chk("R3 err one cycle", {63'd0, wr_err}, 64'd0);
    write_prio(64'h8000_0000_0000_0003);
    #1;
    chk("R3 top bit err", {63'd0, wr_err}, 64'd1);
    chk("R1 readback", rd_data, 64'd6);

    // R10: request in the write cycle uses the old threshold
    write_prio(64'd3);
    @(negedge clk);
    wr_en = 1'b1; wr_data = 64'd9;
    req_valid = 1'b1; req_vector = 8'h50;
    #1;
    chk("R10 old threshold", {63'd0, req_accept}, 64'd1);
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
    #1;
    chk("R10 new threshold", {63'd0, req_accept}, 64'd0);
    req_valid = 1'b0;

    // R4: reset in mid-run clears the threshold
    write_prio(64'd7);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R4 reset clears", rd_data, 64'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule